// File: doc/BRIEF.md
# Masked Interrupt Flag Controller

This block collects interrupt requests from fourteen peripheral and pin sources into sticky flag bits. It qualifies them with software mask bits and turns the highest-priority pending request into a fixed program vector for the CPU. Peripherals deliver single-cycle request pulses. One external pin, called EXT3 here, is sampled through a synchronizer and can raise its request on a rising edge, a falling edge, or both, as two select inputs choose. Separate rising and falling detection flags record which edge occurred.

Software reaches the flags and masks through a small register port with four 8-bit registers. Reading a flag register returns only the flag bits whose mask bit is set. Writing a flag register can clear bits but can never set them. An internal master enable is set by a pulse and cleared when the CPU acknowledges an interrupt. The request line is raised only while that enable is set and some masked flag is pending. Two sources have automatic clearing: the EXT0 flag is held clear while its enable is low, and the UART error flag is held clear while the UART is disabled.

Top module: `irq_flag_ctrl`

## Requirements
- R1: A synchronous active-low reset clears every flag, every mask bit and the master enable, so `irq_o` is 0 and `vector_o` is 0 after reset.
- R2: A one-cycle pulse on `src_pulse_i[i]` sets flag i at that clock edge. The flag then stays set until software clears it, or until the automatic clear in R9 or R10 applies to it.
- R3: A write to a flag register ANDs the stored flags with the written byte, so a 0 bit clears its flag and a 1 bit keeps it unchanged. A write never sets a flag. A hardware set in the same cycle as a clearing write wins.
- R4: The four register addresses are fixed:
  - Address 0 reads flags 0..7.
  - Address 1 reads flags 8..13 in bits 0..5, the rising-edge detection flag in bit 6 and the falling-edge detection flag in bit 7.
  - Addresses 2 and 3 hold the matching mask bits.
  
  A read of address 0 or 1 returns the flags ANDed with the mask. A read of address 2 or 3 returns the mask unchanged.
- R5: `irq_o` is 1 exactly when the master enable is set and, for at least one source 0..13, both the flag and its mask bit are 1.
- R6: `vector_o` gives the vector of the lowest-numbered source that has both its flag and its mask bit set, or 0x000 when no such source exists. The sources are numbered 0..13, with these vectors:

  | Source | Name | Vector |
  |---|---|---|
  | 0 | watchdog | 0x003 |
  | 1 | EXT0 | 0x006 |
  | 2 | tick-counter overflow | 0x009 |
  | 3 | EXT1 | 0x00F |
  | 4 | time base | 0x012 |
  | 5 | UART transmit empty | 0x015 |
  | 6 | UART receive full | 0x018 |
  | 7 | UART error | 0x01B |
  | 8 | timer 3 | 0x021 |
  | 9 | SPI | 0x024 |
  | 10 | timer 4 | 0x027 |
  | 11 | EXT3 | 0x030 |
  | 12 | ADC done | 0x033 |
  | 13 | EXT5 | 0x036 |
- R7: A pulse on `gie_set_i` sets the master enable and a pulse on `ack_i` clears it. If both arrive in the same cycle, the acknowledge wins.
- R8: The EXT3 pin passes through a two-flop synchronizer.
  - A rising edge while `ext3_rise_en_i` is 1 sets the rising-edge detection flag and flag 11.
  - A falling edge while `ext3_fall_en_i` is 1 sets the falling-edge detection flag and flag 11.
  - The flag changes at the third clock edge after the pin changes.
- R9: While `ext0_en_i` is 0, flag 1 is cleared and cannot be set.
- R10: While `uart_en_i` is 0, flag 7 is cleared and cannot be set.
- R11: `src_pulse_i[11]` has no effect, because flag 11 is set only from the EXT3 pin.
- R12: An edge whose select input is 0 sets neither its detection flag nor flag 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_pulse_i | input | 14 | One-cycle request pulses, one bit per source number |
| ext3_pin_i | input | 1 | Asynchronous EXT3 pin level |
| ext3_rise_en_i | input | 1 | Rising-edge select for EXT3 |
| ext3_fall_en_i | input | 1 | Falling-edge select for EXT3 |
| ext0_en_i | input | 1 | EXT0 enable; 0 holds flag 1 clear |
| uart_en_i | input | 1 | UART enable; 0 holds flag 7 clear |
| gie_set_i | input | 1 | Pulse that sets the master enable |
| ack_i | input | 1 | CPU acknowledge pulse; clears the master enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address 0..3 |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt request to the CPU |
| vector_o | output | 13 | Vector of the winning pending source |

## Verification
The bench targets several corner cases, each with the failure it would expose:
- **Clearing write plus hardware set.** A write that clears a flag in the same cycle that hardware sets it checks that the set wins. A design that gets this wrong drops a request.
- **Writing all ones.** A write of all ones to an empty flag register checks that software cannot raise a flag, which would cause a spurious interrupt.
- **Vector walk.** With several sources pending at once, clearing the winners one at a time walks the vector upward. A reversed or shifted priority shows up immediately as a wrong vector.
- **Pin edges.** EXT3 edges are driven with each select input on and off. A missing synchronizer stage, or an edge accepted while its select is off, shows up as a flag that appears one cycle early or appears at all.
- **Automatic clears and the ignored pulse bit.** Pulses arrive while EXT0 or the UART is disabled, and a pulse is sent on bit 11. Each checks that no stale flag survives.
- **Acknowledge with set.** Acknowledge and enable-set in the same cycle check that the acknowledge wins.

// File: rtl/irqc_pkg.sv
// Shared constants for the masked interrupt flag controller: source
// numbering (which is also the priority order), register map and the
// fixed vector table.
package irqc_pkg;

    localparam int NSRC    = 14;
    localparam int DATA_W  = 8;
    localparam int VEC_W   = 13;
    localparam int FLAG_W  = NSRC + 2;
    localparam int ADDR_W  = 2;

    localparam int SRC_WDT  = 0;
    localparam int SRC_EXT0 = 1;
    localparam int SRC_TCK  = 2;
    localparam int SRC_EXT1 = 3;
    localparam int SRC_TBS  = 4;
    localparam int SRC_UTX  = 5;
    localparam int SRC_URX  = 6;
    localparam int SRC_UERR = 7;
    localparam int SRC_TM3  = 8;
    localparam int SRC_SPI  = 9;
    localparam int SRC_TM4  = 10;
    localparam int SRC_EXT3 = 11;
    localparam int SRC_ADC  = 12;
    localparam int SRC_EXT5 = 13;
    localparam int BIT_RISE = 14;
    localparam int BIT_FALL = 15;

    typedef enum logic [ADDR_W-1:0] {
        REG_FLAG_LO = 2'd0,
        REG_FLAG_HI = 2'd1,
        REG_MASK_LO = 2'd2,
        REG_MASK_HI = 2'd3
    } reg_sel_e;

    // Fixed vector for a source number; 0 is the reset vector.
    function automatic logic [VEC_W-1:0] src_vector(input int idx);
        case (idx)
            SRC_WDT:  return 13'h003;
            SRC_EXT0: return 13'h006;
            SRC_TCK:  return 13'h009;
            SRC_EXT1: return 13'h00F;
            SRC_TBS:  return 13'h012;
            SRC_UTX:  return 13'h015;
            SRC_URX:  return 13'h018;
            SRC_UERR: return 13'h01B;
            SRC_TM3:  return 13'h021;
            SRC_SPI:  return 13'h024;
            SRC_TM4:  return 13'h027;
            SRC_EXT3: return 13'h030;
            SRC_ADC:  return 13'h033;
            SRC_EXT5: return 13'h036;
            default:  return 13'h000;
        endcase
    endfunction

endpackage

// File: rtl/irqc_edge_sync.sv
// Synchronizes an asynchronous pin through STAGES flops and reports
// single-cycle rising and falling edges of the synchronized level.
// Assumes STAGES >= 2 and the pin is low while reset is applied.
module irqc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Synchronizer chain, stage 0 samples the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= pin_i;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Each further stage copies the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[s] <= 1'b0;
                else        sync_q[s] <= sync_q[s-1];
            end
        end
    endgenerate

    // Holds the synchronized level of the previous cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign rise_o =  sync_q[STAGES-1] & ~prev_q;
    assign fall_o = ~sync_q[STAGES-1] &  prev_q;

endmodule

// File: rtl/irqc_flag_bank.sv
// Sticky flag bits. Hardware sets, software clears by writing 0 into a
// bit of the low or high half; a 1 written keeps the bit. A forced
// clear overrides everything. Assumes FLAG_W == 2*DATA_W.
module irqc_flag_bank #(
    parameter int FLAG_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set_i,
    input  logic [FLAG_W-1:0] force_clr_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [FLAG_W-1:0] flag_o
);

    generate
        for (genvar b = 0; b < FLAG_W; b++) begin : g_flag
            logic keep;
            // Decide whether a software write lets this bit survive.
            if (b < DATA_W) begin : g_lo
                assign keep = ~wr_lo_i | wdata_i[b];
            end else begin : g_hi
                assign keep = ~wr_hi_i | wdata_i[b-DATA_W];
            end

            // One flag: forced clear, else keep-and-set.
            always_ff @(posedge clk) begin
                if (!rst_n)              flag_o[b] <= 1'b0;
                else if (force_clr_i[b]) flag_o[b] <= 1'b0;
                else                     flag_o[b] <= (flag_o[b] & keep) | set_i[b];
            end
        end
    endgenerate

endmodule

// File: rtl/irqc_regs.sv
// Register port: mask storage, write decode toward the flag bank and
// the read multiplexer that returns flags ANDed with their masks.
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic [2*DW-1:0]   flag_i,
    output logic [2*DW-1:0]   mask_o,
    output logic              wr_flag_lo_o,
    output logic              wr_flag_hi_o,
    output logic [DW-1:0]     rdata_o
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(addr_i);

    assign wr_flag_lo_o = we_i && (sel == REG_FLAG_LO);
    assign wr_flag_hi_o = we_i && (sel == REG_FLAG_HI);

    // Mask halves, plain read/write storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o <= '0;
        end else if (we_i) begin
            if (sel == REG_MASK_LO) mask_o[DW-1:0]    <= wdata_i;
            if (sel == REG_MASK_HI) mask_o[2*DW-1:DW] <= wdata_i;
        end
    end

    // Read selection; flag halves are returned masked.
    always_comb begin
        unique case (sel)
            REG_FLAG_LO: rdata_o = flag_i[DW-1:0]    & mask_o[DW-1:0];
            REG_FLAG_HI: rdata_o = flag_i[2*DW-1:DW] & mask_o[2*DW-1:DW];
            REG_MASK_LO: rdata_o = mask_o[DW-1:0];
            default:     rdata_o = mask_o[2*DW-1:DW];
        endcase
    end

endmodule

// File: rtl/irqc_prio.sv
// Fixed-priority resolver: the lowest-numbered pending source wins and
// its vector from the package table is returned; 0 when none pends.
module irqc_prio
    import irqc_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0]     pend_i,
    output logic             any_o,
    output logic [VEC_W-1:0] vector_o
);

    assign any_o = |pend_i;

    // Scan from the highest number down so the lowest pending one is last written.
    always_comb begin
        vector_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) vector_o = src_vector(i);
        end
    end

endmodule

// File: rtl/irq_flag_ctrl.sv
// Masked interrupt flag controller top. Combines pulse and pin sources
// into sticky flags, applies masks and the master enable, and drives the
// request and vector. Assumes request pulses last one cycle and the
// EXT3 pin is asynchronous.
module irq_flag_ctrl
    import irqc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_pulse_i,
    input  logic              ext3_pin_i,
    input  logic              ext3_rise_en_i,
    input  logic              ext3_fall_en_i,
    input  logic              ext0_en_i,
    input  logic              uart_en_i,
    input  logic              gie_set_i,
    input  logic              ack_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o,
    output logic [VEC_W-1:0]  vector_o
);

    localparam logic [NSRC-1:0] PIN_SRC = NSRC'(1) << SRC_EXT3;

    logic              rise_edge, fall_edge, rise_hit, fall_hit;
    logic [FLAG_W-1:0] set_vec, clr_vec, flag_q, mask_q;
    logic              wr_lo, wr_hi, any_pend, gie_q;

    irqc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(ext3_pin_i),
        .rise_o(rise_edge), .fall_o(fall_edge)
    );

    assign rise_hit = rise_edge & ext3_rise_en_i;
    assign fall_hit = fall_edge & ext3_fall_en_i;

    // Build per-flag set and forced-clear vectors.
    always_comb begin
        set_vec[NSRC-1:0] = (src_pulse_i & ~PIN_SRC)
                          | ({NSRC{rise_hit | fall_hit}} & PIN_SRC);
        set_vec[BIT_RISE] = rise_hit;
        set_vec[BIT_FALL] = fall_hit;
        clr_vec           = '0;
        clr_vec[SRC_EXT0] = ~ext0_en_i;
        clr_vec[SRC_UERR] = ~uart_en_i;
    end

    irqc_flag_bank #(.FLAG_W(FLAG_W), .DATA_W(DATA_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(set_vec), .force_clr_i(clr_vec),
        .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wdata_i(reg_wdata_i),
        .flag_o(flag_q)
    );

    irqc_regs #(.DW(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .flag_i(flag_q), .mask_o(mask_q),
        .wr_flag_lo_o(wr_lo), .wr_flag_hi_o(wr_hi), .rdata_o(reg_rdata_o)
    );

    irqc_prio #(.N(NSRC)) u_prio (
        .pend_i(flag_q[NSRC-1:0] & mask_q[NSRC-1:0]),
        .any_o(any_pend), .vector_o(vector_o)
    );

    // Master enable: acknowledge clears with priority over set.
    always_ff @(posedge clk) begin
        if (!rst_n)         gie_q <= 1'b0;
        else if (ack_i)     gie_q <= 1'b0;
        else if (gie_set_i) gie_q <= 1'b1;
    end

    assign irq_o = gie_q & any_pend;

endmodule

// File: rtl/irq_flag_ctrl_chk.sv
// Property checker bound to irq_flag_ctrl; observes ports plus the
// flag and mask state.
module irq_flag_ctrl_chk
    import irqc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] pulse_lo,
    input logic              ext0_en_i,
    input logic              uart_en_i,
    input logic              ack_i,
    input logic              reg_we_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic              wdata0,
    input logic [DATA_W-1:0] reg_rdata_o,
    input logic              irq_o,
    input logic [VEC_W-1:0]  vector_o,
    input logic [NSRC-1:0]   flag_q,
    input logic [NSRC-1:0]   mask_q
);

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[SRC_WDT] && !(reg_we_i && reg_addr_i == 2'd0 && !wdata0)) |=> flag_q[SRC_WDT]);

    assert_no_sw_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && reg_addr_i == 2'd0 && pulse_lo == '0)
        |=> ((flag_q[DATA_W-1:0] & ~$past(flag_q[DATA_W-1:0])) == '0));

    assert_read_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == 2'd0) |-> ((reg_rdata_o & ~mask_q[DATA_W-1:0]) == '0));

    assert_irq_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((flag_q & mask_q) != '0));

    assert_vector_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (vector_o != '0));

    assert_ack_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !irq_o);

    assert_ext0_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ext0_en_i |=> !flag_q[SRC_EXT0]);

    assert_uerr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !uart_en_i |=> !flag_q[SRC_UERR]);

endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pulse_lo(src_pulse_i[7:0]),
    .ext0_en_i(ext0_en_i), .uart_en_i(uart_en_i), .ack_i(ack_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .wdata0(reg_wdata_i[0]),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o), .vector_o(vector_o),
    .flag_q(flag_q[13:0]), .mask_q(mask_q[13:0])
);

// File: tb/irq_flag_ctrl_tb_top.sv
// Bench: behavioural reference model updated on each rising edge and
// compared with every output after each edge.
module irq_flag_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] src_pulse = '0;
    logic        pin = 1'b0, rise_en = 1'b0, fall_en = 1'b0;
    logic        ext0_en = 1'b1, uart_en = 1'b1;
    logic        gie_set = 1'b0, ack = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq;
    logic [12:0] vector;

    int errors = 0;
    int checks = 0;
    string phase = "R1";
    bit done = 0;

    always #10 clk = ~clk;

    irq_flag_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_pulse_i(src_pulse), .ext3_pin_i(pin),
        .ext3_rise_en_i(rise_en), .ext3_fall_en_i(fall_en),
        .ext0_en_i(ext0_en), .uart_en_i(uart_en), .gie_set_i(gie_set),
        .ack_i(ack), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq), .vector_o(vector)
    );

    // Reference model state
    logic [15:0] m_flag = '0, m_mask = '0, m_set;
    bit m_gie = 0;
    bit h1 = 0, h2 = 0, h3 = 0, m_rise, m_fall;

    function automatic logic [12:0] vec_of(int s);
        int tbl[14] = '{3, 6, 9, 15, 18, 21, 24, 27, 33, 36, 39, 48, 51, 54};
        return 13'(tbl[s]);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flag = '0; m_mask = '0; m_gie = 0; h1 = 0; h2 = 0; h3 = 0;
        end else begin
            m_rise = h2 && !h3;
            m_fall = !h2 && h3;
            h3 = h2; h2 = h1; h1 = pin;
            m_set = {2'b00, src_pulse};
            m_set[14] = m_rise && rise_en;
            m_set[15] = m_fall && fall_en;
            m_set[11] = m_set[14] | m_set[15];
            if (we) begin
                case (addr)
                    2'd0: m_flag[7:0]  = m_flag[7:0] & wdata;
                    2'd1: m_flag[15:8] = m_flag[15:8] & wdata;
                    2'd2: m_mask[7:0]  = wdata;
                    default: m_mask[15:8] = wdata;
                endcase
            end
            m_flag = m_flag | m_set;
            if (!ext0_en) m_flag[1] = 1'b0;
            if (!uart_en) m_flag[7] = 1'b0;
            if (ack) m_gie = 0;
            else if (gie_set) m_gie = 1;
        end
    end

    task automatic check(bit ok, string req, int act, int exp, string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [13:0] p;
        logic [12:0] ev;
        logic [7:0]  er;
        p  = m_flag[13:0] & m_mask[13:0];
        ev = '0;
        for (int i = 13; i >= 0; i--) if (p[i]) ev = vec_of(i);
        case (addr)
            2'd0: er = m_flag[7:0] & m_mask[7:0];
            2'd1: er = m_flag[15:8] & m_mask[15:8];
            2'd2: er = m_mask[7:0];
            default: er = m_mask[15:8];
        endcase
        check(irq === (m_gie && (p != 0)), {phase, "/R5"}, int'(irq), int'(m_gie && (p != 0)), "irq");
        check(vector === ev, {phase, "/R6"}, int'(vector), int'(ev), "vector");
        check(rdata === er, {phase, "/R4"}, int'(rdata), int'(er), "rdata");
    endtask

    // One clock: outputs settle after the edge, then are compared.
    task automatic tick();
        @(posedge clk);
        #5;
        compare();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic pulse(logic [13:0] v);
        src_pulse = v; tick(); src_pulse = '0;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        we = 1; addr = a; wdata = d; tick(); we = 0;
    endtask

    initial begin
        // R1: reset state
        idle(3);
        rst_n = 1'b1;
        for (int a = 0; a < 4; a++) begin addr = 2'(a); tick(); end
        check(irq === 1'b0 && vector === 13'h0, "R1", int'(irq), 0, "post-reset idle");

        // R2/R4: unmask all, set each source by pulse, read back
        phase = "R2";
        wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
        addr = 2'd0;
        for (int s = 0; s < 14; s++) begin
            if (s != 11) pulse(14'(1) << s);
            addr = (s < 8) ? 2'd0 : 2'd1; tick();
        end
        idle(3);

        // R6: priority walk with master enable
        phase = "R6";
        gie_set = 1; tick(); gie_set = 0;
        check(vector === 13'h003, "R6", int'(vector), 3, "winner with all pending");
        for (int s = 0; s < 8; s++) wr(2'd0, ~(8'(1) << s));
        check(vector === 13'h021, "R6", int'(vector), 33, "winner after low half cleared");
        wr(2'd1, 8'h00);
        check(irq === 1'b0, "R5", int'(irq), 0, "no pending request");

        // R4: partial masks gate read-back and request
        phase = "R4";
        pulse(14'h3FFF);
        wr(2'd2, 8'hA5); addr = 2'd0; tick();
        wr(2'd3, 8'h14); addr = 2'd1; tick();
        wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);

        // R3: writing ones never sets; set beats clear in the same cycle
        phase = "R3";
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
        addr = 2'd0; tick();
        check(rdata === 8'h00, "R3", int'(rdata), 0, "write of ones set a flag");
        we = 1; addr = 2'd0; wdata = 8'h00; src_pulse = 14'h0004; tick();
        we = 0; src_pulse = '0; tick();
        check(rdata === 8'h04, "R3", int'(rdata), 4, "set lost to clearing write");
        wr(2'd0, 8'h00);

        // R7: enable, acknowledge, both together
        phase = "R7";
        pulse(14'h0001);
        gie_set = 1; tick(); gie_set = 0;
        ack = 1; tick(); ack = 0;
        check(irq === 1'b0, "R7", int'(irq), 0, "ack did not drop request");
        gie_set = 1; ack = 1; tick(); gie_set = 0; ack = 0;
        check(irq === 1'b0, "R7", int'(irq), 0, "set beat ack");
        gie_set = 1; tick(); gie_set = 0;
        wr(2'd0, 8'h00);

        // R8/R12: pin edges with the edge selects
        phase = "R8";
        addr = 2'd1;
        rise_en = 1; fall_en = 0;
        pin = 1; idle(2);
        check(rdata[6] === 1'b0, "R8", int'(rdata), 0, "rise flag too early");
        tick();
        check(rdata === 8'h48, "R8", int'(rdata), 8'h48, "rise flag and source flag");
        pin = 0; idle(5);
        check(rdata[7] === 1'b0, "R12", int'(rdata), 0, "disabled fall edge latched");
        wr(2'd1, 8'h00);
        phase = "R12";
        rise_en = 0; fall_en = 1;
        pin = 1; idle(5);
        check(rdata === 8'h00, "R12", int'(rdata), 0, "disabled rise edge latched");
        pin = 0; idle(4);
        check(rdata === 8'h88, "R8", int'(rdata), 8'h88, "fall flag and source flag");
        rise_en = 1; pin = 1; idle(4); pin = 0; idle(4);
        wr(2'd1, 8'h00);

        // R11: pulse bit of the pin source is ignored
        phase = "R11";
        pulse(14'h0800); tick();
        check(rdata === 8'h00, "R11", int'(rdata), 0, "pulse bit 11 set a flag");

        // R9: EXT0 enable low clears and blocks
        phase = "R9";
        addr = 2'd0;
        pulse(14'h0002);
        ext0_en = 0; tick();
        pulse(14'h0002); tick();
        check(rdata[1] === 1'b0, "R9", int'(rdata), 0, "EXT0 flag survived disable");
        ext0_en = 1; tick();

        // R10: UART disable clears and blocks the error flag
        phase = "R10";
        pulse(14'h0080);
        uart_en = 0; pulse(14'h0080); tick();
        check(rdata[7] === 1'b0, "R10", int'(rdata), 0, "UART error flag survived disable");
        uart_en = 1; tick();

        // Mixed random traffic, model compared every cycle
        phase = "R5";
        for (int n = 0; n < 3000; n++) begin
            src_pulse = 14'($urandom & $urandom & $urandom);
            pin       = ($urandom % 7 == 0) ? ~pin : pin;
            rise_en   = $urandom % 2;
            fall_en   = $urandom % 2;
            ext0_en   = ($urandom % 10) != 0;
            uart_en   = ($urandom % 10) != 0;
            gie_set   = ($urandom % 6) == 0;
            ack       = ($urandom % 8) == 0;
            we        = ($urandom % 3) == 0;
            addr      = 2'($urandom);
            wdata     = 8'($urandom);
            tick();
        end
        src_pulse = '0; we = 0; gie_set = 0; ack = 0;
        tick();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule